// File: doc/BRIEF.md
# Low-Power Tick and Pulse Counter

This block is a 16-bit up-counter with a small synchronous register port. It has two modes. In time mode it counts ticks of its own clock, either directly or through a power-of-two prescaler. In pulse mode it counts active edges on one of four external inputs. Each input has a selectable polarity and an optional glitch filter. The same 4-bit setting code sets the prescaler divide in time mode and the filter length in pulse mode.

A compare register sets the period. On the tick where the count equals the compare value, the block does three things. It sets a sticky match flag, it drives a one-cycle trigger pulse, and it either returns the count to zero or, when free-running is selected, keeps counting up to the 16-bit wrap. The interrupt output is high while both the flag and the interrupt enable are set. To read the live count, software first writes any value to the counter address. That write copies the count into a holding register, and later reads of that address return the held copy.

The sequencing is a two-state machine. In OFF the counter, prescaler and filter are held at rest. A control write with the run bit set takes the GO transition to RUN. In RUN the block counts, and a control write with the run bit clear takes the HALT transition back to OFF.

Top module: `lp_tick_counter`

## Requirements
- R1: After reset the control register reads 0x0100: bypass set and every other field zero. The compare register and the held count read 0, and `irq` and `trig` are low.
- R2: In time mode with bypass set (control bit 8 = 1, bit 1 = 0), the count rises by one on every clock edge in RUN. The first increment lands on the edge after the GO write.
- R3: In time mode with bypass clear, setting code N (control bits 12:9) gives one count per 2^(N+1) clocks. After the GO edge, k further edges leave the count at floor(k / 2^(N+1)).
- R4: A tick that finds the count equal to the compare value (address 1) does three things on the same edge: it sets the match flag (control bit 7), it raises `trig` for exactly that one cycle, and, when free-running is off (control bit 2 = 0), it returns the count to 0.
- R5: With free-running on, a match does not reset the count; the count wraps only from 0xFFFF to 0.
- R6: The match flag stays set until a control write with bit 7 = 1 clears it. `irq` is high exactly when the flag and the interrupt enable (control bit 6) are both 1.
- R7: A control write with the run bit (bit 0) clear takes HALT to OFF and returns the count to 0. The match flag keeps its value.
- R8: A write of any value to address 2 copies the live count into the holding register. Reads of address 2 return that copy, which does not change until the next such write.
- R9: In pulse mode (control bit 1 = 1) with bypass set, the count rises once per active edge of the input chosen by control bits 4:3. The active edge is rising for polarity bit 5 = 0 and falling for polarity bit 5 = 1. The other three inputs have no effect.
- R10: In pulse mode with bypass clear, a level change on the chosen input is accepted only after it has been sampled unchanged for 2^N consecutive clocks. Code 0 acts as 2 clocks, and shorter glitches are not counted.
- R11: A read of address 0 returns the current run state and configuration fields at the bit positions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler and filter sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 2 | Register address: 0 control/status, 1 compare, 2 count snapshot |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pulse_in | input | 4 | External pulse inputs |
| irq | output | 1 | Interrupt request: match flag AND interrupt enable |
| trig | output | 1 | One-cycle pulse on each compare match |

## Verification
Every result is due on a known edge. A register write takes effect on the edge it straddles. In bypass time mode the count after the k-th edge following GO is k. A snapshot write on edge j latches the count left by edge j-1. The match flag and `trig` appear in the cycle after the edge on which the matching tick is taken. For prescaled and pulse counting, the bench reaches a chosen edge count or waits for the input to settle, then takes a snapshot, which removes the filter and edge-detect latency from the result. All outputs are sampled at the falling edge, with reads one time unit later, so no check depends on process order at the rising edge.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int NUM_IN = 4;
    localparam int SEL_W  = $clog2(NUM_IN);
    localparam int CODE_W = 4;
    localparam int PRE_W  = (1 << CODE_W) + 1;

    localparam int B_RUN  = 0;
    localparam int B_MODE = 1;
    localparam int B_FREE = 2;
    localparam int B_SEL  = 3;
    localparam int B_POL  = B_SEL + SEL_W;
    localparam int B_IE   = B_POL + 1;
    localparam int B_FLAG = B_IE + 1;
    localparam int B_BYP  = B_FLAG + 1;
    localparam int B_CODE = B_BYP + 1;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CMP  = 2'd1,
        ADDR_SNAP = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              bypass;
        logic              ie;
        logic              pol;
        logic [SEL_W-1:0]  sel;
        logic              free;
        logic              mode;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{code: '0, bypass: 1'b1, ie: 1'b0, pol: 1'b0,
                                   sel: '0, free: 1'b0, mode: 1'b0};

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_st_e;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              run,
    input  logic              flag,
    input  logic [CNT_W-1:0]  live_cnt,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  cmp,
    output logic [CNT_W-1:0]  snap,
    output logic              ctrl_wr,
    output logic              run_req,
    output logic              flag_clr,
    output logic [DATA_W-1:0] reg_rdata
);
    logic wr_cmp, wr_snap;

    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_cmp   = reg_wr && (reg_addr == ADDR_CMP);
    assign wr_snap  = reg_wr && (reg_addr == ADDR_SNAP);
    assign run_req  = reg_wdata[B_RUN];
    assign flag_clr = ctrl_wr && reg_wdata[B_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (ctrl_wr) begin
            cfg.mode   <= reg_wdata[B_MODE];
            cfg.free   <= reg_wdata[B_FREE];
            cfg.sel    <= reg_wdata[B_SEL +: SEL_W];
            cfg.pol    <= reg_wdata[B_POL];
            cfg.ie     <= reg_wdata[B_IE];
            cfg.bypass <= reg_wdata[B_BYP];
            cfg.code   <= reg_wdata[B_CODE +: CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp  <= '0;
            snap <= '0;
        end else begin
            if (wr_cmp)  cmp  <= reg_wdata[CNT_W-1:0];
            if (wr_snap) snap <= live_cnt;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[B_RUN]              = run;
                reg_rdata[B_MODE]             = cfg.mode;
                reg_rdata[B_FREE]             = cfg.free;
                reg_rdata[B_SEL +: SEL_W]     = cfg.sel;
                reg_rdata[B_POL]              = cfg.pol;
                reg_rdata[B_IE]               = cfg.ie;
                reg_rdata[B_FLAG]             = flag;
                reg_rdata[B_BYP]              = cfg.bypass;
                reg_rdata[B_CODE +: CODE_W]   = cfg.code;
            end
            ADDR_CMP:  reg_rdata = DATA_W'(cmp);
            ADDR_SNAP: reg_rdata = DATA_W'(snap);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_tick_src.sv
module lpt_tick_src
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode,
    input  logic              bypass,
    input  logic              pol,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CODE_W-1:0] code,
    input  logic [NUM_IN-1:0] pins,
    output logic              tick
);
    logic [PRE_W-1:0]  pre_q, pre_lim, flt_q, flt_len;
    logic [NUM_IN-1:0] pick;
    logic              raw, lvl_q, prev_q, pre_hit, edge_hit;

    // One-hot masked input choice
    for (genvar i = 0; i < NUM_IN; i++) begin : g_pick
        assign pick[i] = pins[i] && (sel == SEL_W'(i));
    end

    assign raw      = (|pick) ^ pol;
    assign pre_lim  = (PRE_W'(1) << (int'(code) + 1)) - PRE_W'(1);
    assign flt_len  = PRE_W'(1) << ((code == '0) ? 1 : int'(code));
    assign pre_hit  = (pre_q == pre_lim);
    assign edge_hit = lvl_q && !prev_q;
    assign tick     = run && (mode ? edge_hit : (bypass || pre_hit));

    // Prescaler: rests at zero while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || mode || bypass) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_hit ? '0 : pre_q + PRE_W'(1);
        end
    end

    // Level filter and edge history; tracks the input while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
            flt_q  <= '0;
        end else if (!run) begin
            lvl_q  <= raw;
            prev_q <= raw;
            flt_q  <= '0;
        end else begin
            prev_q <= lvl_q;
            if (bypass) begin
                lvl_q <= raw;
                flt_q <= '0;
            end else if (raw == lvl_q) begin
                flt_q <= '0;
            end else if (flt_q == flt_len - PRE_W'(1)) begin
                lvl_q <= raw;
                flt_q <= '0;
            end else begin
                flt_q <= flt_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             run_req,
    input  logic             flag_clr,
    input  logic             tick,
    input  logic             free,
    input  logic [CNT_W-1:0] cmp,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             trig
);
    run_st_e state_q, state_d;
    logic    hit;

    // GO: OFF -> RUN on a control write with run set; HALT: RUN -> OFF on one with run clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctrl_wr && run_req)  state_d = ST_RUN;
            ST_RUN: if (ctrl_wr && !run_req) state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign run = (state_q == ST_RUN);
    assign hit = run && tick && (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            trig <= 1'b0;
            flag <= 1'b0;
        end else begin
            trig <= hit;
            if (!run)      cnt <= '0;
            else if (tick) cnt <= (hit && !free) ? '0 : cnt + CNT_W'(1);
            if (hit)           flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/lp_tick_counter.sv
module lp_tick_counter
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_IN-1:0] pulse_in,
    output logic              irq,
    output logic              trig
);
    cfg_t             cfg_w;
    logic [CNT_W-1:0] cmp_w, snap_w, cnt_w;
    logic             ctrl_wr_w, run_req_w, flag_clr_w, run_w, flag_w, tick_w;

    lpt_regs i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .run(run_w), .flag(flag_w), .live_cnt(cnt_w),
        .cfg(cfg_w), .cmp(cmp_w), .snap(snap_w), .ctrl_wr(ctrl_wr_w),
        .run_req(run_req_w), .flag_clr(flag_clr_w), .reg_rdata(reg_rdata)
    );

    lpt_tick_src i_src (
        .clk(clk), .rst_n(rst_n), .run(run_w), .mode(cfg_w.mode),
        .bypass(cfg_w.bypass), .pol(cfg_w.pol), .sel(cfg_w.sel),
        .code(cfg_w.code), .pins(pulse_in), .tick(tick_w)
    );

    lpt_core i_core (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr_w), .run_req(run_req_w),
        .flag_clr(flag_clr_w), .tick(tick_w), .free(cfg_w.free), .cmp(cmp_w),
        .run(run_w), .cnt(cnt_w), .flag(flag_w), .trig(trig)
    );

    assign irq = flag_w && cfg_w.ie;
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker
    import lpt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wflag,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             free,
    input logic             flag,
    input logic             trig,
    input logic [CNT_W-1:0] snap
);
    logic cfg_wr;
    assign cfg_wr = reg_wr && (reg_addr == ADDR_CTRL || reg_addr == ADDR_CMP);

    a_r4_trig_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> flag);

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !free && cnt <= cmp && !cfg_wr) |=> (cnt <= cmp));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr && reg_addr == ADDR_CTRL && wflag)) |=> flag);

    a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_SNAP) |=> $stable(snap));
endmodule

bind lp_tick_counter lpt_checker i_lpt_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wflag(reg_wdata[lpt_pkg::B_FLAG]), .run(run_w), .cnt(cnt_w), .cmp(cmp_w),
    .free(cfg_w.free), .flag(flag_w), .trig(trig), .snap(snap_w)
);

// File: tb/test_lp_tick_counter.sv
module test_lp_tick_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [3:0]  pulse_in = 4'd0;
    logic        irq, trig;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lp_tick_counter i_lp_tick_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_in(pulse_in),
        .irq(irq), .trig(trig)
    );

    function automatic logic [15:0] ctl(bit run, bit mode, bit free, int sel, bit pol,
                                        bit ie, bit clr, bit byp, int code);
        logic [15:0] v = '0;
        v[0] = run; v[1] = mode; v[2] = free; v[4:3] = sel[1:0]; v[5] = pol;
        v[6] = ie; v[7] = clr; v[8] = byp; v[12:9] = code[3:0];
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic snap_read(output int v);
        wr(2'd2, 16'h0);
        rd(2'd2, v);
    endtask

    task automatic pulse(int idx, bit act, int hi, int lo);
        pulse_in[idx] = act;
        repeat (hi) @(negedge clk);
        pulse_in[idx] = ~act;
        repeat (lo) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(2'd0, v); check("R1 ctrl reset", v, 16'h0100);
        check("R11 bypass field", (v >> 8) & 1, 1);
        rd(2'd1, v); check("R1 cmp reset", v, 0);
        rd(2'd2, v); check("R1 snap reset", v, 0);
        check("R1 irq reset", int'(irq), 0);
        check("R1 trig reset", int'(trig), 0);
    endtask

    task automatic t_bypass_count();
        int v;
        wr(2'd1, 16'd1000);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 1, 0));
        rd(2'd0, v); check("R11 run field", v & 1, 1);
        repeat (20) @(negedge clk);
        snap_read(v); check("R2 count per clock", v, 20);
        repeat (7) @(negedge clk);
        rd(2'd2, v); check("R8 held copy unchanged", v, 20);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 1, 0));
        @(negedge clk);
        snap_read(v); check("R7 halt clears count", v, 0);
    endtask

    task automatic t_match();
        int v;
        wr(2'd1, 16'd5);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 1, 0));
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            check("R4 trig timing", int'(trig), (k == 6 || k == 12) ? 1 : 0);
            if (k == 5) begin rd(2'd0, v); check("R4 flag before match", (v >> 7) & 1, 0); end
            if (k == 7) begin
                rd(2'd0, v); check("R6 flag sticky", (v >> 7) & 1, 1);
                check("R6 irq masked", int'(irq), 0);
            end
        end
        wr(2'd0, ctl(0, 0, 0, 0, 0, 1, 0, 1, 0));
        rd(2'd0, v); check("R7 flag kept after halt", (v >> 7) & 1, 1);
        check("R6 irq when enabled", int'(irq), 1);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 1, 1, 1, 0));
        rd(2'd0, v); check("R6 flag cleared by one", (v >> 7) & 1, 0);
        check("R6 irq after clear", int'(irq), 0);
    endtask

    task automatic t_free();
        int v;
        wr(2'd1, 16'd3);
        wr(2'd0, ctl(1, 0, 1, 0, 0, 0, 0, 1, 0));
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check("R4 free trig timing", int'(trig), (k == 4) ? 1 : 0);
        end
        repeat (65536 + 10 - 6) @(negedge clk);
        snap_read(v); check("R5 wraps at 16 bits", v, 10);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 1, 1, 0));
    endtask

    task automatic t_prescale();
        int v;
        wr(2'd1, 16'd1000);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 2));
        wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 2));
        repeat (37) @(negedge clk);
        snap_read(v); check("R3 divide by 8", v, 4);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 0));
        repeat (21) @(negedge clk);
        snap_read(v); check("R3 divide by 2", v, 10);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 1, 0));
    endtask

    task automatic t_pulse();
        int v;
        pulse_in = 4'b0000;
        wr(2'd0, ctl(0, 1, 0, 2, 0, 0, 0, 1, 0));
        wr(2'd0, ctl(1, 1, 0, 2, 0, 0, 0, 1, 0));
        for (int p = 0; p < 5; p++) begin
            pulse_in[0] = ~pulse_in[0];
            pulse_in[3] = ~pulse_in[3];
            pulse(2, 1'b1, 3, 3);
        end
        repeat (4) @(negedge clk);
        snap_read(v); check("R9 rising edges on input 2", v, 5);
        wr(2'd0, ctl(0, 1, 0, 2, 1, 0, 0, 1, 0));
        pulse_in = 4'b0100;
        @(negedge clk);
        wr(2'd0, ctl(1, 1, 0, 2, 1, 0, 0, 1, 0));
        for (int p = 0; p < 4; p++) begin
            pulse_in[1] = ~pulse_in[1];
            pulse(2, 1'b0, 3, 3);
        end
        repeat (4) @(negedge clk);
        snap_read(v); check("R9 falling edges active low", v, 4);
        wr(2'd0, ctl(0, 1, 0, 1, 0, 0, 0, 1, 0));
        pulse_in = 4'b0000;
        @(negedge clk);
        wr(2'd0, ctl(1, 1, 0, 1, 0, 0, 0, 1, 0));
        for (int p = 0; p < 3; p++) pulse(2, 1'b1, 3, 3);
        snap_read(v); check("R9 unselected input ignored", v, 0);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 1, 0));
    endtask

    task automatic t_filter();
        int v;
        pulse_in = 4'b0000;
        wr(2'd0, ctl(0, 1, 0, 3, 0, 0, 0, 0, 2));
        wr(2'd0, ctl(1, 1, 0, 3, 0, 0, 0, 0, 2));
        for (int p = 0; p < 3; p++) pulse(3, 1'b1, 3, 6);
        for (int p = 0; p < 2; p++) pulse(3, 1'b1, 6, 6);
        snap_read(v); check("R10 filter of 4 samples", v, 2);
        wr(2'd0, ctl(0, 1, 0, 3, 0, 0, 0, 0, 0));
        wr(2'd0, ctl(1, 1, 0, 3, 0, 0, 0, 0, 0));
        for (int p = 0; p < 3; p++) pulse(3, 1'b1, 1, 3);
        for (int p = 0; p < 3; p++) pulse(3, 1'b1, 3, 3);
        snap_read(v); check("R10 code 0 acts as 2 samples", v, 3);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 1, 0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass_count();
        t_match();
        t_free();
        t_prescale();
        t_pulse();
        t_filter();
        finish_run();
    end
endmodule